// File: doc/BRIEF.md
# Eight-Way Mesh Router with Shared Circular Buffers

This block is the buffering and steering core of a mesh router that can send traffic in eight directions: the four cardinal ones and the four diagonals. Only four circular FIFOs exist, one per cardinal direction. Each diagonal stream is stored in the FIFO of an adjacent cardinal direction. The router therefore covers eight directions with half the buffer storage that eight dedicated queues would need.

Every incoming word carries a 3-bit direction field above its payload. On the write side the block decodes that field. It picks the shared FIFO that the word belongs to and grants at most one writer per FIFO in each cycle. The full word, direction included, is kept in the FIFO. On the read side the word at the head of each FIFO is presented on the output port that its stored direction names. The word stays there until that output accepts it.

Top module: `octo_router`

## Requirements
- R1: An input word is `{dir[2:0], payload[PW-1:0]}` with dir encoded 0=N, 1=NE, 2=E, 3=SE, 4=S, 5=SW, 6=W, 7=NW. A word with direction d is stored in FIFO d/2, so NE shares the N queue, SE the E queue, SW the S queue and NW the W queue. Once accepted, the word appears on output d.
- R2: Output d is valid only while the head of FIFO d/2 holds a word whose stored direction equals d. The two outputs fed by one FIFO are never valid together.
- R3: Each shared FIFO delivers its words in acceptance order, whether they are cardinal or diagonal. out_data slice d carries the payload of the head word.
- R4: Each FIFO accepts at most one word per cycle. Among the ports that offer words to the same FIFO, a cardinal word beats a diagonal word. Within the same class, the lowest port index wins. Ports that lose the arbitration see in_ready low.
- R5: While a FIFO holds DEPTH words it refuses every write, including in a cycle in which its head is being read.
- R6: An empty FIFO drives neither of its two outputs valid.
- R7: While out_valid[d] is high and out_ready[d] is low, out_valid[d] stays high and the payload on slice d does not change in the next cycle.
- R8: After reset all FIFOs are empty and all outputs are invalid.
- R9: A FIFO accepts exactly DEPTH words before it reports full. The read and write pointers wrap around the storage and carry a wrap bit that separates full from empty.
- R10: in_ready[p] is only high in cycles where in_valid[p] is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | NPORT | Word offered on each ingress port |
| in_word | input | NPORT*(PW+3) | Ingress words, port p at bits [p*(PW+3) +: PW+3] |
| in_ready | output | NPORT | Word on port p accepted this cycle |
| out_valid | output | 8 | Word available on each output direction |
| out_data | output | 8*PW | Payload per output direction, direction d at bits [d*PW +: PW] |
| out_ready | input | 8 | Output direction d takes its word this cycle |

## Verification
The checker watches several properties on every cycle. It confirms that the two outputs of one FIFO are never valid together and that a stalled output holds its word. It confirms that grants only go to valid ports, that a cardinal writer always blocks a diagonal writer aimed at the same queue, and that a full FIFO whose head is not read stays full. The bench scenarios alone can show the correct mapping of all eight directions onto the four queues. They also cover ordering across a mix of cardinal and diagonal words, exact capacity, refusal of a write in the same cycle as a read, and correct data after many pointer wraps. The bench compares every cycle of random traffic against a queue model.

// File: rtl/octo_router.sv
module octo_router #(
  parameter int NPORT = 2,
  parameter int PW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORT-1:0]         in_valid,
  input  logic [NPORT*(PW+3)-1:0]  in_word,
  output logic [NPORT-1:0]         in_ready,
  output logic [7:0]               out_valid,
  output logic [8*PW-1:0]          out_data,
  input  logic [7:0]               out_ready
);
  localparam int W  = PW + 3;
  localparam int AW = $clog2(DEPTH);

  logic [3:0]         full, empty, wen, ren;
  logic [3:0][W-1:0]  wdat, head;
  logic [NPORT-1:0]   gnt;

  // cardinal words first, then diagonal; lowest port wins inside a class
  always_comb begin
    gnt  = '0;
    wen  = '0;
    wdat = '0;
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 2; c++) begin
        for (int p = 0; p < NPORT; p++) begin
          if (!wen[k] && !full[k] && in_valid[p] &&
              in_word[p*W+PW +: 3] == 3'(2*k + c)) begin
            wen[k]  = 1'b1;
            gnt[p]  = 1'b1;
            wdat[k] = in_word[p*W +: W];
          end
        end
      end
    end
  end

  assign in_ready = gnt;

  genvar k, d;
  generate
    for (k = 0; k < 4; k++) begin : g_q
      logic [W-1:0] mem [DEPTH];
      logic [AW:0]  wp, rp;

      assign empty[k] = (wp == rp);
      assign full[k]  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
      assign head[k]  = mem[rp[AW-1:0]];
      assign ren[k]   = !empty[k] && out_ready[head[k][W-1:PW]];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wp <= '0;
          rp <= '0;
        end else begin
          if (wen[k]) wp <= wp + 1'b1;
          if (ren[k]) rp <= rp + 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (wen[k]) mem[wp[AW-1:0]] <= wdat[k];
      end
    end

    for (d = 0; d < 8; d++) begin : g_out
      assign out_valid[d]         = !empty[d/2] && (head[d/2][W-1:PW] == 3'(d));
      assign out_data[d*PW +: PW] = head[d/2][PW-1:0];
    end
  endgenerate
endmodule

module octo_router_chk #(
  parameter int NPORT = 2,
  parameter int PW    = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORT-1:0]        in_valid,
  input logic [NPORT*(PW+3)-1:0] in_word,
  input logic [NPORT-1:0]        in_ready,
  input logic [7:0]              out_valid,
  input logic [8*PW-1:0]         out_data,
  input logic [7:0]              out_ready,
  input logic [3:0]              full,
  input logic [3:0]              ren
);
  localparam int W = PW + 3;

  genvar p, q, k, d;
  generate
    for (p = 0; p < NPORT; p++) begin : g_p
      // R10
      ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready[p] |-> in_valid[p]);
      for (q = 0; q < NPORT; q++) begin : g_q
        if (p != q) begin : g_pair
          // R4
          cardinal_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[p] && in_valid[q] && !in_word[p*W+PW] &&
             in_word[q*W+PW +: 3] == {in_word[p*W+PW+1 +: 2], 1'b1}) |-> !in_ready[q]);
        end
      end
    end
    for (k = 0; k < 4; k++) begin : g_k
      // R2
      pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid[2*k +: 2]));
      // R5
      full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full[k] && !ren[k]) |=> full[k]);
    end
    for (d = 0; d < 8; d++) begin : g_d
      // R7
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[d] && !out_ready[d]) |=> (out_valid[d] && $stable(out_data[d*PW +: PW])));
    end
  endgenerate
endmodule

bind octo_router octo_router_chk #(.NPORT(NPORT), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .full(full), .ren(ren)
);

// File: tb/sim_octo_router.sv
`timescale 1ns/1ps
module sim_octo_router;
  localparam int NPORT = 2, PW = 8, DEPTH = 4, W = PW + 3;

  logic clk = 0, rst_n = 0;
  logic [NPORT-1:0] in_valid = '0;
  logic [NPORT*W-1:0] in_word = '0;
  logic [NPORT-1:0] in_ready;
  logic [7:0] out_valid, out_ready = '0;
  logic [8*PW-1:0] out_data;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [W-1:0] mq [4][$];

  octo_router #(.NPORT(NPORT), .PW(PW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready));

  always #2 clk = ~clk;

  function automatic logic [W-1:0] mk(input int d, input logic [PW-1:0] pl);
    return {3'(d), pl};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] v, input logic [W-1:0] w0, input logic [W-1:0] w1,
                      input logic [7:0] ordy);
    logic [1:0] eg;
    logic [3:0] taken;
    logic [W-1:0] w;
    @(negedge clk);
    in_valid = v; in_word = {w1, w0}; out_ready = ordy;
    #1;
    eg = '0; taken = '0;
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < NPORT; p++) begin
        w = p ? w1 : w0;
        if (v[p] && w[PW] == c[0] && !taken[w[W-1:PW+1]] && mq[w[W-1:PW+1]].size() < DEPTH) begin
          taken[w[W-1:PW+1]] = 1'b1;
          eg[p] = 1'b1;
        end
      end
    chk(in_ready == eg, "R4 grant", 64'(in_ready), 64'(eg));
    for (int d = 0; d < 8; d++) begin
      bit ev;
      ev = mq[d/2].size() > 0 && mq[d/2][0][W-1:PW] == 3'(d);
      chk(out_valid[d] == ev, "R2 valid", 64'(out_valid[d]), 64'(ev));
      if (ev) chk(out_data[d*PW +: PW] == mq[d/2][0][PW-1:0], "R3 data",
                  64'(out_data[d*PW +: PW]), 64'(mq[d/2][0][PW-1:0]));
    end
    for (int k = 0; k < 4; k++)
      if (mq[k].size() > 0 && ordy[mq[k][0][W-1:PW]]) void'(mq[k].pop_front());
    for (int p = 0; p < NPORT; p++)
      if (eg[p]) begin
        w = p ? w1 : w0;
        mq[w[W-1:PW+1]].push_back(w);
      end
  endtask

  task automatic drain();
    for (int i = 0; i < 4*DEPTH; i++) step(2'b00, '0, '0, 8'hFF);
  endtask

  initial begin
    logic [7:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 8'h00, "R8 reset outputs", 64'(out_valid), 64'h0);
    @(negedge clk);
    rst_n = 1;
    step(2'b00, '0, '0, 8'h00);
    chk(out_valid == 8'h00, "R8 idle after reset", 64'(out_valid), 64'h0);
    chk(in_ready == 2'b00, "R10 no grant without valid", 64'(in_ready), 64'h0);

    // R1: each direction lands on its own output
    for (int d = 0; d < 8; d++) begin
      step(2'b01, mk(d, 8'hA0 + 8'(d)), '0, 8'h00);
      step(2'b00, '0, '0, 8'hFF);
      chk(out_valid == 8'(1 << d), "R1 steering", 64'(out_valid), 64'(1 << d));
    end
    drain();

    // R9 capacity then R5 refusal
    for (int i = 0; i < DEPTH; i++) begin
      step(2'b01, mk(1, 8'(i)), '0, 8'h00);
      chk(in_ready == 2'b01, "R9 accept below depth", 64'(in_ready), 64'h1);
    end
    step(2'b01, mk(0, 8'h55), '0, 8'h00);
    chk(in_ready == 2'b00, "R5 full refuses cardinal", 64'(in_ready), 64'h0);
    step(2'b01, mk(1, 8'h66), '0, 8'h02);
    chk(in_ready == 2'b00, "R5 full refuses during read", 64'(in_ready), 64'h0);
    drain();
    chk(out_valid == 8'h00, "R6 empty has no valid", 64'(out_valid), 64'h0);

    // R4 conflicts
    step(2'b11, mk(1, 8'h11), mk(0, 8'h22), 8'h00);
    chk(in_ready == 2'b10, "R4 cardinal beats diagonal", 64'(in_ready), 64'h2);
    step(2'b11, mk(2, 8'h33), mk(2, 8'h44), 8'h00);
    chk(in_ready == 2'b01, "R4 low port wins cardinal tie", 64'(in_ready), 64'h1);
    step(2'b11, mk(5, 8'h77), mk(5, 8'h88), 8'h00);
    chk(in_ready == 2'b01, "R4 low port wins diagonal tie", 64'(in_ready), 64'h1);
    drain();

    // R7 hold while stalled, R3 mixed order
    step(2'b01, mk(3, 8'h9C), '0, 8'h00);
    step(2'b01, mk(2, 8'h9D), '0, 8'h00);
    held = out_data[3*PW +: PW];
    for (int i = 0; i < 3; i++) begin
      step(2'b00, '0, '0, 8'h00);
      chk(out_valid[3] && out_data[3*PW +: PW] == held, "R7 stall hold",
          64'(out_data[3*PW +: PW]), 64'(held));
    end
    step(2'b00, '0, '0, 8'h08);
    step(2'b00, '0, '0, 8'h00);
    chk(out_valid[2] && out_data[2*PW +: PW] == 8'h9D, "R3 order after diagonal",
        64'(out_data[2*PW +: PW]), 64'h9D);
    drain();

    // random mix: pointer wrap (R9) and ordering (R3) against the model
    for (int i = 0; i < 4000; i++)
      step(2'($urandom), mk(int'($urandom % 8), 8'($urandom)),
           mk(int'($urandom % 8), 8'($urandom)), 8'($urandom | $urandom));
    drain();
    chk(out_valid == 8'h00, "R6 empty after random drain", 64'(out_valid), 64'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule